// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Front End

This block is the digital side of a four-channel 8-bit voltage DAC. A host drives three asynchronous wires: serial data, serial clock and a load strobe. Through them it shifts in an 11-bit command word that carries a channel address, a range bit and an 8-bit code. When the load strobe falls, the word is written into the addressed channel's input latch.

Every channel holds its value twice: once in an input latch and once in an output latch. A separate load-DAC input sets when the output latches change. While that input is low, a write reaches the addressed channel's output latch straight away. While it is high, writes are only staged in the input latches. Its next high-to-low transition then moves all four staged values to the outputs in the same cycle.

The four output codes and four range bits drive the resistor-string converters and gain stages, which lie outside this block. All strobes are sampled into one system clock.

Top module: `qdac_ctrl`

## Requirements
- R1: A command is 11 bits sent most-significant bit first, in the order A1, A0, RNG, D7 … D0. Only the last 11 bits shifted before the load strobe falls are used, and any earlier bits are discarded.
- R2: A bit is taken only on a falling edge of `ser_clk` while `ser_ld` is high. Serial clock edges while `ser_ld` is low do not change the shifted word.
- R3: A1A0 = 0 addresses channel A, 1 addresses B, 2 addresses C and 3 addresses D. Channel n appears on `ch_code[8n+7:8n]` and on `ch_rng[n]`.
- R4: A falling edge of `ser_ld` writes the code and range bit into the addressed channel's input latch only. The other channels' input latches keep their contents.
- R5: If the synchronized `ld_dac` is low when a load strobe fall is detected, the addressed channel's output is updated by the third system clock edge after the input change.
- R6: While `ld_dac` is high, no output code or range bit changes, whatever writes arrive.
- R7: A high-to-low transition of `ld_dac` copies all four input latches to the outputs in the same cycle. A write detected in that same cycle is included in the copy.
- R8: Reset clears every code to 0 and every range bit to 0 (×1 range), and it also clears the shift register. A load strobe with no bits shifted after reset therefore writes code 0, range 0 to channel A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acting at the clock edge |
| ser_dat | input | 1 | Serial command data (asynchronous) |
| ser_clk | input | 1 | Serial clock; a bit is taken on its falling edge (asynchronous) |
| ser_ld | input | 1 | Load strobe; high while shifting, its falling edge writes (asynchronous) |
| ld_dac | input | 1 | Low: immediate update; high: hold outputs; falling edge: update all (asynchronous) |
| ch_code | output | 32 | Output codes, channel A in bits 7:0 up to channel D in bits 31:24 |
| ch_rng | output | 4 | Output range bits, bit n for channel n |

## Verification
Each strobe goes through two synchronizer flops and one edge-detect flop, so a shift, a latch write or an output transfer takes effect at the third system clock edge after the wire changes. The bench drives every wire at a falling clock edge. It holds each level for at least four clocks, keeps data stable around every serial clock fall, and waits eight clocks after a strobe before it samples the outputs at a falling edge. This waiting applies to every check: the sweep over all channels, both ranges and codes from 0 to 255, the held-output and simultaneous-transfer phases, the extra-bit and junk-clock cases, and the post-reset load.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int DEF_CODE_W      = 8;
   localparam int DEF_SEL_W       = 2;
   localparam int DEF_SYNC_STAGES = 2;

   // Channel names, in address order
   typedef enum logic [1:0] {
      CH_A = 2'd0,
      CH_B = 2'd1,
      CH_C = 2'd2,
      CH_D = 2'd3
   } chan_e;

   function automatic int word_width(input int code_w, input int sel_w);
      return sel_w + 1 + code_w;
   endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = qdac_pkg::DEF_SYNC_STAGES,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
   parameter int WORD_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("qdac_shift: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sreg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        sreg_q <= '0;
      else if (shift_en) sreg_q <= {sreg_q[WORD_W-2:0], bit_in};
   end

   assign word = sreg_q;

   // R1: the newest bit enters at the least significant end
   a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sreg_q[0] == $past(bit_in)));

   // R2: with no qualified serial clock fall, the word is left alone
   a_r2_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sreg_q));
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int CODE_W = qdac_pkg::DEF_CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              ldac_lvl,
   input  logic              ldac_fall,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              wr_rng,
   output logic [CODE_W-1:0] out_code,
   output logic              out_rng
);
   localparam int ENT_W = CODE_W + 1;

   logic [ENT_W-1:0] in_q, out_q, in_nxt;

   assign in_nxt = wr ? {wr_rng, wr_code} : in_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= '0;
         out_q <= '0;
      end else begin
         in_q <= in_nxt;
         if ((wr && !ldac_lvl) || ldac_fall) out_q <= in_nxt;
      end
   end

   assign out_code = out_q[CODE_W-1:0];
   assign out_rng  = out_q[CODE_W];

   // R4: an unaddressed input latch keeps its value
   a_r4_keep_input: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (in_q == $past(in_q)));

   // R5: a write with load-DAC low reaches the output on the next edge
   a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ldac_lvl) |=> (out_q == {$past(wr_rng), $past(wr_code)}));

   // R6: load-DAC high freezes the output
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ldac_lvl |=> $stable(out_q));

   // R7: a load-DAC fall moves the staged value to the output
   a_r7_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (ldac_fall && !wr) |=> (out_q == $past(in_q)));
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl #(
   parameter int CODE_W      = qdac_pkg::DEF_CODE_W,
   parameter int SEL_W       = qdac_pkg::DEF_SEL_W,
   parameter int SYNC_STAGES = qdac_pkg::DEF_SYNC_STAGES
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ser_dat,
   input  logic                          ser_clk,
   input  logic                          ser_ld,
   input  logic                          ld_dac,
   output logic [(CODE_W<<SEL_W)-1:0]    ch_code,
   output logic [(1<<SEL_W)-1:0]         ch_rng
);
   localparam int N_CH   = 1 << SEL_W;
   localparam int WORD_W = qdac_pkg::word_width(CODE_W, SEL_W);

   generate
      if (CODE_W < 1 || SEL_W < 1) begin : g_bad_cfg
         $error("qdac_ctrl: CODE_W and SEL_W must be positive");
      end
   endgenerate

   // synchronized strobes, bit order {ld_dac, ser_ld, ser_clk, ser_dat}
   logic [3:0] s_q;
   qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ld_dac, ser_ld, ser_clk, ser_dat}),
      .dout (s_q)
   );

   logic s_dat, s_clk, s_ld, s_ldac;
   assign {s_ldac, s_ld, s_clk, s_dat} = s_q;

   // previous synchronized levels for edge detection
   logic [2:0] prev_q;
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 3'b110;
      else        prev_q <= {s_ldac, s_ld, s_clk};
   end

   logic sclk_fall, ld_fall, ldac_fall, shift_en;
   assign sclk_fall = prev_q[0] & ~s_clk;
   assign ld_fall   = prev_q[1] & ~s_ld;
   assign ldac_fall = prev_q[2] & ~s_ldac;
   assign shift_en  = sclk_fall & s_ld;

   logic [WORD_W-1:0] word;
   qdac_shift #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .bit_in  (s_dat),
      .word    (word)
   );

   logic [SEL_W-1:0]  w_sel;
   logic              w_rng;
   logic [CODE_W-1:0] w_code;
   assign w_sel  = word[WORD_W-1 -: SEL_W];
   assign w_rng  = word[CODE_W];
   assign w_code = word[CODE_W-1:0];

   logic [N_CH-1:0] wr_vec;

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         assign wr_vec[g] = ld_fall && (w_sel == SEL_W'(g));
         qdac_chan #(.CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_vec[g]),
            .ldac_lvl (s_ldac),
            .ldac_fall(ldac_fall),
            .wr_code  (w_code),
            .wr_rng   (w_rng),
            .out_code (ch_code[g*CODE_W +: CODE_W]),
            .out_rng  (ch_rng[g])
         );
      end
   endgenerate

   // R4: a strobe fall addresses exactly one channel, none otherwise
   a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fall |-> ($countones(wr_vec) == 1));

   // R6: all outputs are frozen while load-DAC is held high
   a_r6_all_hold: assert property (@(posedge clk) disable iff (!rst_n)
      s_ldac |=> ($stable(ch_code) && $stable(ch_rng)));
endmodule

// File: tb/sim_qdac_ctrl.sv
module sim_qdac_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_dat = 1'b0, ser_clk = 1'b0, ser_ld = 1'b1, ld_dac = 1'b0;
   logic [31:0] ch_code;
   logic [3:0]  ch_rng;

   always #2.5 clk = ~clk;

   qdac_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
      .ser_ld(ser_ld), .ld_dac(ld_dac), .ch_code(ch_code), .ch_rng(ch_rng)
   );

   int total = 0;
   int bad   = 0;
   logic [8:0]  exp_in  [4];
   logic [8:0]  exp_out [4];
   logic [10:0] mshift;

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_all(input string req);
      logic [31:0] ec;
      logic [3:0]  er;
      for (int i = 0; i < 4; i++) begin
         ec[i*8 +: 8] = exp_out[i][7:0];
         er[i]        = exp_out[i][8];
      end
      total++;
      if (ch_code !== ec || ch_rng !== er) begin
         bad++;
         $display("FAIL %s: code=%h rng=%b expected code=%h rng=%b",
                  req, ch_code, ch_rng, ec, er);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_clk(5);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         exp_in[i]  = '0;
         exp_out[i] = '0;
      end
      mshift = '0;
      wait_clk(8);
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      if (ser_ld) mshift = {mshift[9:0], b};
      wait_clk(4);
   endtask

   task automatic send_word(input logic [1:0] sel, input logic rng, input logic [7:0] code);
      logic [10:0] w;
      w = {sel, rng, code};
      for (int i = 10; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic model_write();
      int ch;
      ch = int'(mshift[10:9]);
      exp_in[ch] = mshift[8:0];
      if (!ld_dac) exp_out[ch] = mshift[8:0];
   endtask

   // load pulse; junk bits are clocked while the strobe is low
   task automatic pulse_ld(input int junk);
      ser_ld = 1'b0;
      wait_clk(8);
      model_write();
      for (int j = 0; j < junk; j++) send_bit(j[0] ^ 1'b1);
      ser_ld = 1'b1;
      wait_clk(8);
   endtask

   task automatic set_ldac(input logic v);
      if (ld_dac && !v) for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
      ld_dac = v;
      wait_clk(8);
   endtask

   initial begin
      do_reset();
      check_all("R8 reset state");

      // sweep in immediate mode: every channel, both ranges, codes 0..255
      for (int ch = 0; ch < 4; ch++)
         for (int r = 0; r < 2; r++)
            for (int k = 0; k < 18; k++) begin
               send_word(2'(ch), r[0], 8'(k * 15));
               pulse_ld(0);
               check_all("R5 R3 R1 immediate write");
            end

      // R1: extra leading bits are dropped
      for (int j = 0; j < 5; j++) send_bit(1'b1);
      send_word(2'd2, 1'b0, 8'h3c);
      pulse_ld(0);
      check_all("R1 extra leading bits");

      // R6: hold outputs while staging all four channels
      set_ldac(1'b1);
      for (int ch = 0; ch < 4; ch++) begin
         send_word(2'(ch), ch[0], 8'(8'ha5 ^ 8'(ch * 17)));
         pulse_ld(0);
         check_all("R6 outputs held");
      end
      // R7: simultaneous transfer
      set_ldac(1'b0);
      check_all("R7 deferred transfer");

      // R2: clock edges while strobe is low are ignored
      send_word(2'd1, 1'b1, 8'h5a);
      pulse_ld(3);
      check_all("R2 first write");
      pulse_ld(0);
      check_all("R2 rewrite after junk clocks");

      // R4: staged write to B only, then coincident strobe and load-DAC fall
      set_ldac(1'b1);
      send_word(2'd1, 1'b0, 8'h11);
      pulse_ld(0);
      check_all("R4 R6 staged write");
      send_word(2'd2, 1'b1, 8'hee);
      ser_ld = 1'b0;
      ld_dac = 1'b0;
      wait_clk(8);
      exp_in[2] = mshift[8:0];
      for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
      ser_ld = 1'b1;
      wait_clk(8);
      check_all("R7 coincident write and transfer");

      // R8: reset clears shift register and outputs
      do_reset();
      check_all("R8 outputs after reset");
      pulse_ld(0);
      check_all("R8 empty load after reset");
      send_word(2'd3, 1'b1, 8'hff);
      pulse_ld(0);
      check_all("R3 R5 channel D full scale");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule